// File: doc/BRIEF.md
# In-Order Commit Store Buffer

This block holds the stores of an out-of-order core between issue and their write into the data cache. Every store takes a slot when it issues, in program order, before its address or its data are known. The slot index goes back to the issuing logic as the store's identifier. The address part and the data part of the store execute later, in either order, and each one writes only its own field into that slot. When the store retires, the retire logic marks the slot with the same identifier.

A slot leaves the buffer only from the head, and only when it has an address, has data and has retired. It leaves through a single cache write port with a valid/ready handshake, one store per accepted transfer, so stores reach the cache in program order. A full-fence request is answered as complete only once the buffer is empty. A squash input moves the tail back to a given slot and discards the younger slots that have not retired. Slots that have retired are never discarded.

Top module: `store_commit_buffer`

## Requirements
- R1: After reset the buffer is empty: `sb_empty`=1, `sb_full`=0, `cwr_valid`=0 and `alloc_id`=0.
- R2: Each accepted allocation (`alloc_req`=1, `sb_full`=0, `squash_en`=0) returns the current `alloc_id`. The next identifier is that value plus one, modulo DEPTH.
- R3: `sb_full` rises once DEPTH slots are held. While it is high, `alloc_req` is refused and `alloc_id` does not move.
- R4: The address write (`addr_we`) and the data write (`data_we`) may reach a slot in either order. The cache sees the address, byte enables and data that were written for that store.
- R5: A slot with address and data but no retire mark never raises `cwr_valid`.
- R6: If the head slot is incomplete, no younger slot is offered, even if that younger slot is complete and retired. Stores reach the cache strictly in allocation order.
- R7: While `cwr_valid`=1 and `cwr_ready`=0, `cwr_valid`, `cwr_addr`, `cwr_data` and `cwr_be` hold their values. The head moves only on a cycle with both signals high.
- R8: `fence_ok` equals `fence_req` while the buffer is empty, and is 0 while any slot is held.
- R9: A squash with `squash_id` inside the held range sets the tail to `squash_id`. The next `alloc_id` equals `squash_id`, and the discarded slots never reach the cache.
- R10: A squash whose target slot has already retired is ignored, and the tail stays where it was.
- R11: `cwr_valid` rises in the cycle after the clock edge that completes the head slot, which is its last missing address, data or retire write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Reserve a slot for an issuing store |
| alloc_id | output | IDX_W | Identifier of the slot the next allocation takes |
| sb_full | output | 1 | All slots held; allocation refused |
| sb_empty | output | 1 | No slot held |
| addr_we | input | 1 | Store address write |
| addr_id | input | IDX_W | Slot for the address write |
| addr_in | input | ADDR_W | Store address |
| be_in | input | DATA_W/8 | Byte enables |
| data_we | input | 1 | Store data write |
| data_id | input | IDX_W | Slot for the data write |
| data_in | input | DATA_W | Store data |
| ret_we | input | 1 | Retire mark |
| ret_id | input | IDX_W | Slot being retired |
| squash_en | input | 1 | Roll the tail back |
| squash_id | input | IDX_W | New tail slot |
| fence_req | input | 1 | Full-fence request |
| fence_ok | output | 1 | Fence may complete |
| cwr_valid | output | 1 | Cache write offered |
| cwr_ready | input | 1 | Cache accepts the write |
| cwr_addr | output | ADDR_W | Cache write address |
| cwr_data | output | DATA_W | Cache write data |
| cwr_be | output | DATA_W/8 | Cache write byte enables |

## Verification
`alloc_id`, `sb_full`, `sb_empty` and `cwr_valid` come straight from registers. They change one edge after the allocation, write, retire, squash or accepted transfer that causes the change, and the bench samples them at the next falling edge after that edge. `fence_ok` is combinational on `fence_req`, so it is checked in the same cycle the request is driven. The monitor counts a cache transfer at the falling edge before the rising edge that accepts it, and pops the expected store from the queue at that point. Because of this, ordering, payload and stall periods are all checked on the exact cycle of each transfer.

// File: rtl/sb_pkg.sv
package sb_pkg;

    // Per-slot status bits
    typedef struct packed {
        logic valid;
        logic addr_ok;
        logic data_ok;
        logic retired;
    } sb_flags_t;

    // A slot may go to the cache only with all four bits set
    function automatic logic slot_complete(input sb_flags_t f);
        return f.valid & f.addr_ok & f.data_ok & f.retired;
    endfunction

endpackage

// File: rtl/sb_ptr_ctrl.sv
module sb_ptr_ctrl #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_req,
    input  logic             squash_en,
    input  logic [IDX_W-1:0] squash_id,
    input  logic             sq_tgt_retired,
    input  logic             pop,
    output logic [IDX_W-1:0] head_idx,
    output logic [IDX_W-1:0] tail_idx,
    output logic             alloc_fire,
    output logic             full,
    output logic             empty,
    output logic [DEPTH-1:0] discard
);
    // Pointers carry one wrap bit above the index
    logic [IDX_W:0] head_q, tail_q, tail_d, count, keep_cnt;
    logic           squash_ok;

    assign head_idx = head_q[IDX_W-1:0];
    assign tail_idx = tail_q[IDX_W-1:0];
    assign count    = tail_q - head_q;
    assign empty    = (head_q == tail_q);
    assign full     = (head_q[IDX_W] != tail_q[IDX_W]) && (head_idx == tail_idx);

    // Slots kept after a squash = distance from head to target
    assign keep_cnt  = {1'b0, IDX_W'(squash_id - head_idx)};
    assign squash_ok = squash_en && (keep_cnt < count) && !sq_tgt_retired;
    assign alloc_fire = alloc_req && !full && !squash_en;

    always_comb begin
        tail_d = tail_q;
        if (squash_ok)
            tail_d = head_q + keep_cnt;
        else if (alloc_fire)
            tail_d = tail_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            tail_q <= tail_d;
            if (pop)
                head_q <= head_q + 1'b1;
        end
    end

    // Slots at or past the target, inside the held range, are dropped
    for (genvar i = 0; i < DEPTH; i++) begin : g_disc
        logic [IDX_W-1:0] off;
        assign off        = IDX_W'(i) - head_idx;
        assign discard[i] = squash_ok && ({1'b0, off} >= keep_cnt) && ({1'b0, off} < count);
    end
endmodule

// File: rtl/sb_entry_array.sv
module sb_entry_array
    import sb_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_fire,
    input  logic [IDX_W-1:0]  tail_idx,
    input  logic              addr_we,
    input  logic [IDX_W-1:0]  addr_id,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [BE_W-1:0]   be_in,
    input  logic              data_we,
    input  logic [IDX_W-1:0]  data_id,
    input  logic [DATA_W-1:0] data_in,
    input  logic              ret_we,
    input  logic [IDX_W-1:0]  ret_id,
    input  logic              pop,
    input  logic [IDX_W-1:0]  head_idx,
    input  logic [DEPTH-1:0]  discard,
    input  logic [IDX_W-1:0]  squash_id,
    output sb_flags_t         head_flags,
    output logic [ADDR_W-1:0] head_addr,
    output logic [DATA_W-1:0] head_data,
    output logic [BE_W-1:0]   head_be,
    output logic              sq_tgt_retired
);
    sb_flags_t         flags [DEPTH];
    logic [ADDR_W-1:0] addr_mem [DEPTH];
    logic [DATA_W-1:0] data_mem [DEPTH];
    logic [BE_W-1:0]   be_mem   [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        sb_flags_t fl_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                fl_q <= '0;
            end else if ((pop && head_idx == IDX_W'(i)) || discard[i]) begin
                fl_q <= '0;
            end else if (alloc_fire && tail_idx == IDX_W'(i)) begin
                fl_q <= '{valid: 1'b1, default: 1'b0};
            end else if (fl_q.valid) begin
                if (addr_we && addr_id == IDX_W'(i)) fl_q.addr_ok <= 1'b1;
                if (data_we && data_id == IDX_W'(i)) fl_q.data_ok <= 1'b1;
                if (ret_we  && ret_id  == IDX_W'(i)) fl_q.retired <= 1'b1;
            end
        end
        assign flags[i] = fl_q;
    end

    always_ff @(posedge clk) begin
        if (addr_we) begin
            addr_mem[addr_id] <= addr_in;
            be_mem[addr_id]   <= be_in;
        end
        if (data_we)
            data_mem[data_id] <= data_in;
    end

    assign head_flags     = flags[head_idx];
    assign head_addr      = addr_mem[head_idx];
    assign head_data      = data_mem[head_idx];
    assign head_be        = be_mem[head_idx];
    assign sq_tgt_retired = flags[squash_id].retired;
endmodule

// File: rtl/store_commit_buffer.sv
module store_commit_buffer
    import sb_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_req,
    output logic [IDX_W-1:0]  alloc_id,
    output logic              sb_full,
    output logic              sb_empty,
    input  logic              addr_we,
    input  logic [IDX_W-1:0]  addr_id,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [BE_W-1:0]   be_in,
    input  logic              data_we,
    input  logic [IDX_W-1:0]  data_id,
    input  logic [DATA_W-1:0] data_in,
    input  logic              ret_we,
    input  logic [IDX_W-1:0]  ret_id,
    input  logic              squash_en,
    input  logic [IDX_W-1:0]  squash_id,
    input  logic              fence_req,
    output logic              fence_ok,
    output logic              cwr_valid,
    input  logic              cwr_ready,
    output logic [ADDR_W-1:0] cwr_addr,
    output logic [DATA_W-1:0] cwr_data,
    output logic [BE_W-1:0]   cwr_be
);
    sb_flags_t        head_flags;
    logic [IDX_W-1:0] head_idx, tail_idx;
    logic [DEPTH-1:0] discard;
    logic             alloc_fire, pop, sq_tgt_retired;

    assign cwr_valid = slot_complete(head_flags);
    assign pop       = cwr_valid && cwr_ready;
    assign alloc_id  = tail_idx;
    assign fence_ok  = fence_req && sb_empty;

    sb_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk            (clk),
        .rst            (rst),
        .alloc_req      (alloc_req),
        .squash_en      (squash_en),
        .squash_id      (squash_id),
        .sq_tgt_retired (sq_tgt_retired),
        .pop            (pop),
        .head_idx       (head_idx),
        .tail_idx       (tail_idx),
        .alloc_fire     (alloc_fire),
        .full           (sb_full),
        .empty          (sb_empty),
        .discard        (discard)
    );

    sb_entry_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
        .clk            (clk),
        .rst            (rst),
        .alloc_fire     (alloc_fire),
        .tail_idx       (tail_idx),
        .addr_we        (addr_we),
        .addr_id        (addr_id),
        .addr_in        (addr_in),
        .be_in          (be_in),
        .data_we        (data_we),
        .data_id        (data_id),
        .data_in        (data_in),
        .ret_we         (ret_we),
        .ret_id         (ret_id),
        .pop            (pop),
        .head_idx       (head_idx),
        .discard        (discard),
        .squash_id      (squash_id),
        .head_flags     (head_flags),
        .head_addr      (cwr_addr),
        .head_data      (cwr_data),
        .head_be        (cwr_be),
        .sq_tgt_retired (sq_tgt_retired)
    );
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int IDX_W  = 3,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int BE_W   = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              alloc_req,
    input logic              squash_en,
    input logic [IDX_W-1:0]  alloc_id,
    input logic              sb_full,
    input logic              sb_empty,
    input logic              fence_req,
    input logic              fence_ok,
    input logic              cwr_valid,
    input logic              cwr_ready,
    input logic [ADDR_W-1:0] cwr_addr,
    input logic [DATA_W-1:0] cwr_data,
    input logic [BE_W-1:0]   cwr_be
);
    // R2: an accepted allocation advances the identifier by one
    p_alloc_step_r2: assert property (@(posedge clk) disable iff (rst)
        (alloc_req && !sb_full && !squash_en) |=> alloc_id == IDX_W'($past(alloc_id) + 1'b1));

    // R3: a refused allocation leaves the identifier unchanged
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (alloc_req && sb_full && !squash_en) |=> alloc_id == $past(alloc_id));

    // R3: full and empty never both high
    p_full_not_empty_r3: assert property (@(posedge clk) disable iff (rst)
        sb_full |-> !sb_empty);

    // R7: an offered write holds until accepted
    p_hold_offer_r7: assert property (@(posedge clk) disable iff (rst)
        (cwr_valid && !cwr_ready) |=> cwr_valid && $stable(cwr_addr) && $stable(cwr_data) && $stable(cwr_be));

    // R8: fence completes only with nothing left to write
    p_fence_empty_r8: assert property (@(posedge clk) disable iff (rst)
        fence_ok |-> fence_req && !cwr_valid && !sb_full);
endmodule

bind store_commit_buffer sb_checker #(
    .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)
) u_sb_chk (
    .clk(clk), .rst(rst), .alloc_req(alloc_req), .squash_en(squash_en),
    .alloc_id(alloc_id), .sb_full(sb_full), .sb_empty(sb_empty),
    .fence_req(fence_req), .fence_ok(fence_ok), .cwr_valid(cwr_valid),
    .cwr_ready(cwr_ready), .cwr_addr(cwr_addr), .cwr_data(cwr_data), .cwr_be(cwr_be)
);

// File: tb/tb_store_commit_buffer.sv
module tb_store_commit_buffer;
    localparam int DEPTH  = 8;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 64;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int BE_W   = DATA_W / 8;

    typedef struct packed {
        logic [ADDR_W-1:0] a;
        logic [DATA_W-1:0] d;
        logic [BE_W-1:0]   b;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic alloc_req = 0, addr_we = 0, data_we = 0, ret_we = 0, squash_en = 0;
    logic fence_req = 0, cwr_ready = 1;
    logic [IDX_W-1:0]  addr_id = '0, data_id = '0, ret_id = '0, squash_id = '0;
    logic [ADDR_W-1:0] addr_in = '0;
    logic [BE_W-1:0]   be_in = '0;
    logic [DATA_W-1:0] data_in = '0;
    logic [IDX_W-1:0]  alloc_id;
    logic sb_full, sb_empty, fence_ok, cwr_valid;
    logic [ADDR_W-1:0] cwr_addr;
    logic [DATA_W-1:0] cwr_data;
    logic [BE_W-1:0]   cwr_be;

    always #2 clk = ~clk;

    store_commit_buffer #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (.*);

    int errors = 0, checks = 0;
    item_t exp_q[$];
    item_t slot_m [DEPTH];

    task automatic chk(input logic ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Monitor: every accepted transfer must match the oldest expected store
    always @(negedge clk) begin
        if (!rst && cwr_valid && cwr_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9", "unexpected cache write addr", longint'(cwr_addr), 0);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                chk(cwr_addr == e.a, "R6", "commit addr order", longint'(cwr_addr), longint'(e.a));
                chk(cwr_data == e.d, "R4", "commit data", longint'(cwr_data), longint'(e.d));
                chk(cwr_be == e.b, "R4", "commit byte enables", longint'(cwr_be), longint'(e.b));
            end
        end
    end

    // Drivers: each starts one time unit after a rising edge and ends there
    task automatic do_alloc(output logic [IDX_W-1:0] id);
        id = alloc_id;
        alloc_req = 1;
        @(posedge clk); #1 alloc_req = 0;
    endtask
    task automatic do_addr(input logic [IDX_W-1:0] id, input logic [ADDR_W-1:0] a, input logic [BE_W-1:0] b);
        addr_we = 1; addr_id = id; addr_in = a; be_in = b;
        slot_m[id].a = a; slot_m[id].b = b;
        @(posedge clk); #1 addr_we = 0;
    endtask
    task automatic do_data(input logic [IDX_W-1:0] id, input logic [DATA_W-1:0] d);
        data_we = 1; data_id = id; data_in = d;
        slot_m[id].d = d;
        @(posedge clk); #1 data_we = 0;
    endtask
    task automatic do_retire(input logic [IDX_W-1:0] id);
        ret_we = 1; ret_id = id;
        exp_q.push_back(slot_m[id]);
        @(posedge clk); #1 ret_we = 0;
    endtask
    task automatic do_squash(input logic [IDX_W-1:0] id);
        squash_en = 1; squash_id = id;
        @(posedge clk); #1 squash_en = 0;
    endtask
    task automatic store(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input logic [BE_W-1:0] b);
        logic [IDX_W-1:0] id;
        do_alloc(id); do_addr(id, a, b); do_data(id, d); do_retire(id);
    endtask
    task automatic drain(input string req);
        int n;
        n = 0;
        while (!sb_empty && n < 100) begin @(posedge clk); #1; n++; end
        @(negedge clk);
        chk(sb_empty == 1'b1, req, "buffer drained", longint'(sb_empty), 1);
        chk(exp_q.size() == 0, req, "all expected stores written", longint'(exp_q.size()), 0);
        @(posedge clk); #1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        logic [IDX_W-1:0] id0, id1, id2, idx, last;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(sb_empty == 1, "R1", "empty after reset", longint'(sb_empty), 1);
        chk(sb_full == 0, "R1", "not full after reset", longint'(sb_full), 0);
        chk(cwr_valid == 0, "R1", "no write after reset", longint'(cwr_valid), 0);
        chk(alloc_id == 0, "R1", "first id", longint'(alloc_id), 0);
        fence_req = 1; #0.1;
        chk(fence_ok == 1, "R8", "fence ok when empty", longint'(fence_ok), 1);
        fence_req = 0;
        @(posedge clk); #1;

        // R2 consecutive ids; R4 data-before-address order
        do_alloc(id0); do_alloc(id1); do_alloc(id2);
        chk(id0 == 0 && id1 == 1 && id2 == 2, "R2", "ids in order", longint'({id0, id1, id2}), 'o012);
        do_data(id1, 64'h1111_2222_3333_4444);
        do_addr(id1, 32'h0000_1010, 8'h0F);
        do_addr(id0, 32'h0000_2000, 8'hFF); do_data(id0, 64'hAAAA_5555_0000_FFFF);
        do_addr(id2, 32'h0000_3030, 8'hF0); do_data(id2, 64'h0123_4567_89AB_CDEF);
        @(negedge clk);
        chk(cwr_valid == 0, "R5", "no write before retire", longint'(cwr_valid), 0);
        @(posedge clk); #1;
        do_retire(id0); do_retire(id1); do_retire(id2);
        drain("R4");

        // R11 timing and R7 stall hold
        cwr_ready = 0;
        do_alloc(id0); do_addr(id0, 32'h0000_4444, 8'h3C); do_data(id0, 64'hDEAD_BEEF_CAFE_F00D);
        repeat (2) @(posedge clk); #1;
        @(negedge clk);
        chk(cwr_valid == 0, "R5", "complete but unretired", longint'(cwr_valid), 0);
        @(posedge clk); #1;
        do_retire(id0);
        @(negedge clk);
        chk(cwr_valid == 1, "R11", "valid one edge after retire", longint'(cwr_valid), 1);
        repeat (3) @(negedge clk);
        chk(cwr_valid == 1 && cwr_addr == 32'h0000_4444, "R7", "offer held while stalled",
            longint'(cwr_addr), 32'h0000_4444);
        chk(sb_empty == 0, "R7", "head kept while stalled", longint'(sb_empty), 0);
        @(posedge clk); #1 cwr_ready = 1;
        drain("R7");

        // R6 incomplete head blocks a complete younger store
        do_alloc(id0); do_alloc(id1);
        do_addr(id1, 32'h0000_5555, 8'h01); do_data(id1, 64'h5);
        do_addr(id0, 32'h0000_6666, 8'h80);
        slot_m[id0].d = 64'h6;
        do_retire(id0); do_retire(id1);
        repeat (2) @(negedge clk);
        chk(cwr_valid == 0, "R6", "younger waits for head", longint'(cwr_valid), 0);
        @(posedge clk); #1;
        do_data(id0, 64'h6);
        drain("R6");

        // R3 fill to full, refuse, R8 fence stall
        for (int k = 0; k < DEPTH; k++) do_alloc(idx);
        @(negedge clk);
        chk(sb_full == 1, "R3", "full after DEPTH allocs", longint'(sb_full), 1);
        last = alloc_id;
        @(posedge clk); #1;
        alloc_req = 1; @(posedge clk); #1 alloc_req = 0;
        @(negedge clk);
        chk(alloc_id == last && sb_full == 1, "R3", "alloc refused when full", longint'(alloc_id), longint'(last));
        fence_req = 1; #0.1;
        chk(fence_ok == 0, "R8", "fence stalls while held", longint'(fence_ok), 0);
        @(posedge clk); #1;
        for (int k = 0; k < DEPTH; k++) begin
            idx = IDX_W'(last + k[IDX_W-1:0]);
            do_addr(idx, 32'h0001_0000 + k, 8'h11 << (k % 2));
            do_data(idx, 64'h100 + k);
            do_retire(idx);
        end
        drain("R3");
        @(negedge clk);
        chk(fence_ok == 1, "R8", "fence completes after drain", longint'(fence_ok), 1);
        @(posedge clk); #1 fence_req = 0;

        // R9 squash rollback discards unretired younger slots
        do_alloc(id0); do_alloc(id1); do_alloc(id2); do_alloc(idx);
        do_addr(id0, 32'h0000_7000, 8'hFF); do_data(id0, 64'h70);
        do_addr(id1, 32'h0000_7100, 8'hFF); do_data(id1, 64'h71);
        do_addr(id2, 32'hBAD0_0002, 8'hFF); do_data(id2, 64'hBAD2);
        do_addr(idx, 32'hBAD0_0003, 8'hFF); do_data(idx, 64'hBAD3);
        do_retire(id0);
        do_squash(id2);
        @(negedge clk);
        chk(alloc_id == id2, "R9", "tail rolled back", longint'(alloc_id), longint'(id2));
        @(posedge clk); #1;
        do_retire(id1);
        do_alloc(last);
        chk(last == id2, "R9", "reused slot id", longint'(last), longint'(id2));
        do_addr(last, 32'h0000_7200, 8'h0F); do_data(last, 64'h72); do_retire(last);
        drain("R9");

        // R10 squash onto a retired slot is ignored
        cwr_ready = 0;
        store(32'h0000_8000, 64'h80, 8'hAA);
        id0 = IDX_W'(alloc_id - 1'b1);
        do_alloc(id1);
        do_squash(id0);
        @(negedge clk);
        chk(alloc_id == IDX_W'(id1 + 1'b1), "R10", "retired target not squashed",
            longint'(alloc_id), longint'(IDX_W'(id1 + 1'b1)));
        @(posedge clk); #1;
        do_squash(id1);
        @(negedge clk);
        chk(alloc_id == id1, "R9", "unretired tail slot squashed", longint'(alloc_id), longint'(id1));
        @(posedge clk); #1 cwr_ready = 1;
        drain("R10");

        // R2 wrap check: many stores through all slots
        for (int k = 0; k < 20; k++) store(32'h0002_0000 + k * 8, 64'h9000 + k, BE_W'(k + 1));
        drain("R2");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule